// File: doc/BRIEF.md
# Two-wire slave with sub-device address decode

This block is the serial front end of a small mixed-function chip. It oversamples the two-wire clock and data lines on the system clock and finds START and STOP conditions. It shifts in the first byte of each transaction and checks that byte's upper nibble against a fixed device-type code. The next three bits of that byte choose one of two internal targets. The first target is a bank of potentiometer wiper registers. The second is a single control register. Bit 0 of the byte selects read or write. Wiper and control values appear on plain register output ports for the logic around the block.

A wiper write takes three bytes: the address, a pointer, then the data. It changes the wiper only when the write-enable bit in the control register is already set. A control write takes two bytes. A bare address byte is a one-byte transaction and is used for polling. A write can be marked as nonvolatile. The block then models the store time with a counter that starts at the STOP closing that write. While the counter runs, address bytes are not acknowledged, so the master can poll until the store completes.

Top module: `twi_subdev_slave`

## Requirements
- R1: An address byte is acknowledged (SDA held low during the ninth SCL clock) only if bits 7:4 equal 1010, bits 3:1 equal 111 (wiper bank) or 010 (control register), and no store cycle is running. Any other address byte gets no acknowledge, and the slave ignores the bus until the next START or STOP.
- R2: Address bit 0 selects the direction: 1 is a read of the selected target and 0 is a write.
- R3: A wiper write has three bytes: address, pointer, data. Pointer bit 7 marks the write as nonvolatile and the low pointer bits pick the wiper. The data byte is acknowledged, but the wiper changes only if control bit 0 (write enable) is 1. Otherwise the wiper keeps its value.
- R4: A control write has two bytes: address, data. Data bits 6:0 are stored, and bit 0 is the write-enable latch. Data bit 7 marks the write as nonvolatile and is not stored, so it always reads back as 0.
- R5: A read returns the wiper chosen by the last written pointer, or the control register, MSB first. The same byte is sent again for as long as the master acknowledges.
- R6: When the master does not acknowledge a read byte, the slave stops driving SDA and ignores further clocks until START or STOP.
- R7: A byte beyond the length of the transaction (a fourth byte to the wiper bank, a third byte to the control register) gets no acknowledge and changes nothing.
- R8: After an accepted nonvolatile write, the STOP ending that transaction starts a store cycle of NVCYC system clocks. While the cycle runs, address bytes get no acknowledge and no register changes. Afterwards addresses are acknowledged again.
- R9: A repeated START aborts the current transaction and restarts byte counting, so the next byte is taken as an address. A repeated START also cancels a pending store.
- R10: The slave only pulls SDA low or releases it, and it changes its SDA drive only while SCL is low.
- R11: After reset all wipers and the control register are 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper_o | output | 8*NPOT | Wiper registers; wiper k at bits 8k+7:8k |
| ctrl_o | output | 8 | Control register; bit 0 is write enable, bit 7 reads 0 |

## Verification
The assertions assume that the master holds SCL low for longer than the three-clock synchroniser delay. They also assume that the master never makes a START or STOP while the slave is pulling SDA low. Under those conditions every change of the slave's drive falls inside a low phase of SCL. The bench master holds each SCL phase for ten system clocks and changes its own SDA only while SCL is low, except for deliberate START and STOP edges. It issues those only after reading a NACKed final byte or after a write acknowledge has ended, when the slave has already released the line.

// File: rtl/twi_subdev_slave.sv
module twi_subdev_slave #(
  parameter int NPOT = 2,
  parameter int NVCYC = 2000,
  parameter logic [2:0] POT_SEL = 3'b111,
  parameter logic [2:0] CSR_SEL = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [8*NPOT-1:0] wiper_o,
  output logic [7:0]        ctrl_o
);
  localparam int PW = (NPOT > 1) ? $clog2(NPOT) : 1;
  localparam int CW = $clog2(NVCYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_WAIT} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  st_t st;
  logic [2:0] bitc;
  logic full, tgt_pot, rd, mack, pend, ptr_nv, oe;
  logic [7:0] sr, txsr, rd_byte;
  logic [1:0] bidx;
  logic [PW-1:0] ptr;
  logic [7:0] wip [NPOT];
  logic [6:0] csr;
  logic [CW-1:0] nvc;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c = scl_s & scl_q & ~sda_q & sda_s;
  wire ptr_ok = int'(ptr) < NPOT;
  wire addr_ok = sr[7:4] == 4'b1010 && (sr[3:1] == POT_SEL || sr[3:1] == CSR_SEL) && nvc == '0;
  wire data_ok = !rd && (tgt_pot ? (bidx == 2'd1 || bidx == 2'd2) : (bidx == 2'd1));
  wire accept = (bidx == 2'd0) ? addr_ok : data_ok;

  always_comb begin
    rd_byte = 8'h00;
    if (tgt_pot) begin
      if (ptr_ok) rd_byte = wip[ptr];
    end else begin
      rd_byte = {1'b0, csr};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nvc <= '0;
    end else if (stop_c && pend) begin
      nvc <= CW'(NVCYC);
    end else if (nvc != '0) begin
      nvc <= nvc - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bitc <= '0;
      full <= 1'b0;
      sr <= '0;
      txsr <= '0;
      bidx <= '0;
      tgt_pot <= 1'b0;
      rd <= 1'b0;
      mack <= 1'b0;
      pend <= 1'b0;
      ptr <= '0;
      ptr_nv <= 1'b0;
      csr <= '0;
      oe <= 1'b0;
      for (int k = 0; k < NPOT; k++) wip[k] <= '0;
    end else if (start_c) begin
      st <= S_RX;
      bitc <= '0;
      full <= 1'b0;
      bidx <= '0;
      pend <= 1'b0;
      oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE;
      pend <= 1'b0;
      oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise) begin
            sr <= {sr[6:0], sda_s};
            bitc <= bitc + 3'd1;
            if (bitc == 3'd7) full <= 1'b1;
          end else if (scl_fall && full) begin
            full <= 1'b0;
            bitc <= '0;
            if (accept) begin
              oe <= 1'b1;
              st <= S_ACK;
              if (bidx == 2'd0) begin
                tgt_pot <= sr[3:1] == POT_SEL;
                rd <= sr[0];
              end else if (tgt_pot && bidx == 2'd1) begin
                ptr <= sr[PW-1:0];
                ptr_nv <= sr[7];
              end else if (tgt_pot) begin
                if (csr[0] && ptr_ok) begin
                  wip[ptr] <= sr;
                  if (ptr_nv) pend <= 1'b1;
                end
              end else begin
                csr <= sr[6:0];
                if (sr[7]) pend <= 1'b1;
              end
            end else begin
              st <= S_WAIT;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            if (rd) begin
              txsr <= rd_byte;
              oe <= ~rd_byte[7];
              st <= S_TX;
            end else begin
              oe <= 1'b0;
              st <= S_RX;
              if (bidx != 2'd3) bidx <= bidx + 2'd1;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitc <= bitc + 3'd1;
            if (bitc == 3'd7) full <= 1'b1;
          end else if (scl_fall) begin
            if (full) begin
              full <= 1'b0;
              oe <= 1'b0;
              st <= S_MACK;
            end else begin
              txsr <= {txsr[6:0], 1'b0};
              oe <= ~txsr[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              txsr <= rd_byte;
              oe <= ~rd_byte[7];
              bitc <= '0;
              st <= S_TX;
            end else begin
              st <= S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe;
  assign ctrl_o = {1'b0, csr};
  for (genvar g = 0; g < NPOT; g++) begin : g_wip
    assign wiper_o[8*g +: 8] = wip[g];
  end
endmodule

// File: rtl/twi_subdev_chk.sv
module twi_subdev_chk #(
  parameter int NPOT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [8*NPOT-1:0] wiper,
  input logic [7:0]        ctrl,
  input logic              busy,
  input logic              in_wait,
  input logic              in_idle,
  input logic              stop_seen
);
  a_r10_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  a_r3_wiper_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper) |-> $past(ctrl[0]));

  a_r8_busy_freezes_regs: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(wiper) && $stable(ctrl)));

  a_r6_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !sda_oe);

  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (in_idle && !sda_oe));
endmodule

bind twi_subdev_slave twi_subdev_chk #(.NPOT(NPOT)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .scl_i(scl_i),
  .sda_oe(sda_oe_o),
  .wiper(wiper_o),
  .ctrl(ctrl_o),
  .busy(nvc != '0),
  .in_wait(st == S_WAIT),
  .in_idle(st == S_IDLE),
  .stop_seen(stop_c)
);

// File: tb/sim_twi_subdev_slave.sv
`timescale 1ns/1ps
module sim_twi_subdev_slave;
  localparam int T = 10;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic oe;
  logic [15:0] wiper;
  logic [7:0] ctrl;
  wire sda = m_sda & ~oe;
  int checks = 0, errors = 0, r10_bad = 0;

  always #5 clk = ~clk;

  twi_subdev_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_oe_o(oe), .wiper_o(wiper), .ctrl_o(ctrl));

  always @(posedge clk) if (rst_n && scl && oe !== $past(oe)) r10_bad++;

  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'b1010_1110}, {1'b1, 8'b1010_0101}, {1'b0, 8'b1010_0000},
    {1'b0, 8'b1011_1110}, {1'b0, 8'b1010_1100}, {1'b0, 8'b0010_0100},
    {1'b1, 8'b1010_1111}, {1'b0, 8'b1010_0011}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (T) @(negedge clk);
  endtask

  task automatic start();
    m_sda = 1'b1; half(); scl = 1'b1; half(); m_sda = 1'b0; half(); scl = 1'b0; half();
  endtask

  task automatic stop();
    m_sda = 1'b0; half(); scl = 1'b1; half(); m_sda = 1'b1; half();
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; half(); scl = 1'b1; half(); scl = 1'b0;
    end
    m_sda = 1'b1; half(); scl = 1'b1; half();
    ack = !sda;
    scl = 1'b0;
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half(); scl = 1'b1; repeat (T/2) @(negedge clk);
      b[i] = sda; repeat (T/2) @(negedge clk); scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1; half(); scl = 1'b1; half(); scl = 1'b0;
    m_sda = 1'b1;
  endtask

  task automatic wr3(input logic [7:0] p, input logic [7:0] d, output bit a1, output bit a2, output bit a3);
    start(); send(8'hAE, a1); send(p, a2); send(d, a3); stop();
  endtask

  task automatic wr_ctrl(input logic [7:0] d, output bit a2);
    bit a1;
    start(); send(8'hA4, a1); send(d, a2); stop();
  endtask

  task automatic poll(output int n, output bit done);
    bit a;
    n = 0; done = 0;
    for (int i = 0; i < 40 && !done; i++) begin
      start(); send(8'hAE, a);
      if (!a) n++; else done = 1;
      stop();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit a, a1, a2, a3, done;
    logic [7:0] b, b2;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(wiper == 16'h0 && ctrl == 8'h0 && !oe, "R11 reset", {wiper, ctrl}, 0);

    for (int v = 0; v < 8; v++) begin
      start(); send(VEC[v][7:0], a);
      chk(a == VEC[v][8], "R1 address ack", a, VEC[v][8]);
      if (a && VEC[v][0]) begin
        recv(1'b0, b);
        chk(b == 8'h00, "R2 read direction", b, 0);
      end
      stop();
    end

    wr3(8'h00, 8'h55, a1, a2, a3);
    chk(a1 && a2 && a3, "R3 acks with wel clear", {a1, a2, a3}, 7);
    chk(wiper == 16'h0000, "R3 write ignored without wel", wiper, 0);

    wr_ctrl(8'h01, a2);
    chk(a2 && ctrl == 8'h01, "R4 ctrl write", ctrl, 1);
    start(); send(8'hA5, a); recv(1'b0, b); stop();
    chk(b == 8'h01, "R5 ctrl read", b, 1);

    wr3(8'h00, 8'hA5, a1, a2, a3);
    wr3(8'h01, 8'h3C, a1, a2, a3);
    chk(wiper == 16'h3CA5, "R3 wiper writes with wel", wiper, 16'h3CA5);

    start(); send(8'hAE, a); send(8'h01, a); stop();
    start(); send(8'hAF, a); recv(1'b1, b); recv(1'b0, b2);
    chk(b == 8'h3C && b2 == 8'h3C, "R5 repeated read", {b, b2}, 16'h3C3C);
    half();
    chk(!oe, "R6 released after nack", oe, 0);
    send(8'h00, a);
    chk(!a, "R6 ignored until stop", a, 0);
    stop();

    start(); send(8'hA4, a); send(8'h03, a1); send(8'h7F, a2); stop();
    chk(a1 && !a2 && ctrl == 8'h03, "R7 ctrl extra byte", {a2, ctrl}, 3);
    start(); send(8'hAE, a); send(8'h00, a); send(8'h11, a1); send(8'h22, a2); stop();
    chk(a1 && !a2 && wiper[7:0] == 8'h11, "R7 wiper extra byte", {a2, wiper[7:0]}, 8'h11);

    wr_ctrl(8'h81, a2);
    chk(ctrl == 8'h01, "R4 bit7 not stored", ctrl, 1);
    poll(n, done);
    chk(done && n >= 2, "R8 ctrl store polling", n, 2);

    wr3(8'h81, 8'h77, a1, a2, a3);
    poll(n, done);
    chk(done && n >= 2 && wiper[15:8] == 8'h77, "R8 wiper store polling", n, 2);

    start(); send(8'hA4, a); start(); send(8'hAE, a1); send(8'h00, a2); send(8'h99, a3); stop();
    chk(wiper[7:0] == 8'h99 && ctrl == 8'h01, "R9 repeated start restarts count", {wiper[7:0], ctrl}, 16'h9901);

    wr_ctrl(8'h00, a2);
    wr3(8'h00, 8'h42, a1, a2, a3);
    chk(wiper[7:0] == 8'h99, "R3 wel cleared blocks write", wiper[7:0], 8'h99);
    start(); send(8'hA5, a); recv(1'b0, b); stop();
    chk(b == 8'h00, "R5 ctrl read after clear", b, 0);

    chk(r10_bad == 0, "R10 drive changes only with scl low", r10_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule